// File: doc/BRIEF.md
# Locked SPI Control Register Bank with Shadow Verification

This block is the serial control port of a 10-bit measurement converter. An SPI host in mode 0 sends 16-bit command frames. Each frame is either a register write, or the first half of a two-frame read. The second frame of a read carries the addressed register's contents back on the data output. All serial inputs are brought into the system clock domain and oversampled, so the host's serial clock must run well below the system clock.

The configuration registers are protected. A write to one of them lands only while a separate unlock register holds a key value. Every configuration register also has a shadow copy at its address plus 0x10. The shadow copies and the unlock register can be written at any time. A validation fault flag comes up at reset. It is evaluated again on every completed write frame, and it clears only once every shadow copy has been written since reset and all copies equal their live registers. One configuration bit, the reference-source select, is brought out as a pin.

Top module: `vreg_spi_bank`

## Requirements
- R1: A frame is 16 bits sent least significant bit first on `mosi`, so frame bit 0 travels first. Bits 15..11 are the register address, bit 10 set means write, and bits 9..0 are the data.
- R2: After a read frame (bit 10 clear), the next frame returns on `miso` a word whose bits 9..0 hold the addressed register and whose bits 15..10 are zero. The word goes out least significant bit first. `miso` changes only after a falling `sclk`, and the host samples it on the rising edge.
- R3: Reads of address 0x00 and address 0x01 return the current value of `sampleIn`.
- R4: A write to a configuration register (0x03 to 0x0A) takes effect only while the unlock register at 0x0C holds the key 0x294. At any other time the write has no effect.
- R5: The unlock register at 0x0C accepts any value at any time and reads back what was written. Any value other than 0x294, including 0, locks the bank.
- R6: Shadow copies at 0x13 to 0x1A (configuration address plus 0x10) can be written whether the bank is locked or not, and they read back their value.
- R7: The fault flag is bit 0 of the flags register at 0x02 and is 1 after reset. It changes only on a completed write frame. It is then 0 only if all eight shadow copies have been written since reset and every copy equals its live register.
- R8: A live-register write that leaves the register unequal to its copy raises the fault flag on that frame. Writing the copy to match clears it again.
- R9: Output `extRefSel` equals bit 5 of the configuration register at 0x09. It is 0 after reset.
- R10: Writes to 0x00 to 0x02 and to unmapped addresses change no register. Reads of unmapped addresses return 0.
- R11: A frame in which chip select is released after a number of `sclk` rising edges other than 16 is discarded. It performs no write and does not change the pending read address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| sampleIn | input | 10 | Converter result returned by reads of 0x00 and 0x01 |
| extRefSel | output | 1 | External reference select, bit 5 of register 0x09 |

## Verification
A single write frame can both change a live or shadow register and settle the fault flag, and both happen on the same system clock. The bench provokes this with the last missing shadow write, which must clear the flag. It also provokes it with a live write that breaks equality, which must raise the flag in that same frame. Each case is judged by reading the flags register back immediately over SPI. A second same-frame coupling is the return of read data while a new command is being shifted in. The bench checks that the read-back frame, which is itself a read of 0x00, delivers the earlier address's data.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  parameter int ADDR_W  = 5;
  parameter int DATA_W  = 10;
  parameter int FRAME_W = ADDR_W + 1 + DATA_W;
  parameter int CNT_W   = $clog2(FRAME_W) + 1;

  parameter logic [ADDR_W-1:0] A_RESULT   = 5'h00;
  parameter logic [ADDR_W-1:0] A_FRESULT  = 5'h01;
  parameter logic [ADDR_W-1:0] A_FLAGS    = 5'h02;
  parameter logic [ADDR_W-1:0] A_CFG_LO   = 5'h03;
  parameter logic [ADDR_W-1:0] A_CFG_HI   = 5'h0A;
  parameter logic [ADDR_W-1:0] A_UNLOCK   = 5'h0C;
  parameter logic [ADDR_W-1:0] SHADOW_OFS = 5'h10;
  parameter logic [ADDR_W-1:0] A_CONFIG   = 5'h09;
  parameter int                EXTREF_BIT = 5;

  parameter int NCFG = int'(A_CFG_HI) - int'(A_CFG_LO) + 1;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/vreg_spi_ctrl.sv
module vreg_spi_ctrl
  import vreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic [DATA_W-1:0] rdWord,
  output logic [ADDR_W-1:0] rdAddr,
  output cmd_t              cmd
);
  localparam int SYNC_N = 3;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] MAX_CNT  = '1;

  logic [SYNC_N-1:0] sclkSync, csSync;
  logic [1:0]        mosiSync;
  logic              sclkRise, sclkFall, csFall, csRise, csActive;
  logic [CNT_W-1:0]  bitCnt;
  logic [FRAME_W-1:0] rxShift, txShift;
  logic [ADDR_W-1:0] frameAddr;
  logic              frameWr;
  logic [DATA_W-1:0] frameData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_N-2:0], sclk};
      csSync   <= {csSync[SYNC_N-2:0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];
  assign csFall   = ~csSync[1] & csSync[2];
  assign csRise   = csSync[1] & ~csSync[2];
  assign csActive = ~csSync[1];

  assign frameAddr = rxShift[FRAME_W-1 -: ADDR_W];
  assign frameWr   = rxShift[DATA_W];
  assign frameData = rxShift[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      rdAddr  <= '0;
      cmd     <= '0;
    end else begin
      cmd.wrStb <= 1'b0;
      if (csFall) begin
        bitCnt  <= '0;
        rxShift <= '0;
        txShift <= {{(FRAME_W-DATA_W){1'b0}}, rdWord};
      end else if (csRise) begin
        txShift <= '0;
        if (bitCnt == FULL_CNT) begin
          if (frameWr) begin
            cmd.wrStb <= 1'b1;
            cmd.addr  <= frameAddr;
            cmd.data  <= frameData;
          end else begin
            rdAddr <= frameAddr;
          end
        end
      end else if (csActive) begin
        if (sclkRise) begin
          rxShift <= {mosiSync[1], rxShift[FRAME_W-1:1]};
          if (bitCnt != MAX_CNT) bitCnt <= bitCnt + 1'b1;
        end else if (sclkFall) begin
          txShift <= {1'b0, txShift[FRAME_W-1:1]};
        end
      end
    end
  end

  assign miso = txShift[0];

  p_short_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && bitCnt != FULL_CNT) |=> (!cmd.wrStb && $stable(rdAddr)));

  p_miso_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && !sclkFall && !csFall) |=> $stable(miso));

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrStb |=> !cmd.wrStb);
endmodule

// File: rtl/vreg_datapath.sv
module vreg_datapath
  import vreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 10'h294
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] rdWord,
  output logic              extRefSel
);
  localparam int CFG_IDX = int'(A_CONFIG) - int'(A_CFG_LO);

  logic [NCFG-1:0][DATA_W-1:0] liveReg, shadowReg, liveNext, shadowNext;
  logic [NCFG-1:0]             touched, touchedNext;
  logic [NCFG-1:0]             liveWe, shadowWe;
  logic [DATA_W-1:0]           unlockReg;
  logic                        unlocked, faultFlag, faultNext;

  assign unlocked = (unlockReg == UNLOCK_KEY);

  always_comb begin
    for (int i = 0; i < NCFG; i++) begin
      liveWe[i]   = cmd.wrStb && unlocked && (cmd.addr == A_CFG_LO + ADDR_W'(i));
      shadowWe[i] = cmd.wrStb && (cmd.addr == A_CFG_LO + SHADOW_OFS + ADDR_W'(i));
    end
  end

  generate
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      assign liveNext[g]    = liveWe[g]   ? cmd.data : liveReg[g];
      assign shadowNext[g]  = shadowWe[g] ? cmd.data : shadowReg[g];
      assign touchedNext[g] = touched[g] | shadowWe[g];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          liveReg[g]   <= '0;
          shadowReg[g] <= '0;
          touched[g]   <= 1'b0;
        end else begin
          liveReg[g]   <= liveNext[g];
          shadowReg[g] <= shadowNext[g];
          touched[g]   <= touchedNext[g];
        end
      end
    end
  endgenerate

  assign faultNext = !(&touchedNext) || (liveNext != shadowNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockReg <= '0;
      faultFlag <= 1'b1;
    end else if (cmd.wrStb) begin
      faultFlag <= faultNext;
      if (cmd.addr == A_UNLOCK) unlockReg <= cmd.data;
    end
  end

  always_comb begin
    rdWord = '0;
    if (rdAddr == A_RESULT || rdAddr == A_FRESULT) begin
      rdWord = sampleIn;
    end else if (rdAddr == A_FLAGS) begin
      rdWord = {{(DATA_W-1){1'b0}}, faultFlag};
    end else if (rdAddr == A_UNLOCK) begin
      rdWord = unlockReg;
    end else begin
      for (int i = 0; i < NCFG; i++) begin
        if (rdAddr == A_CFG_LO + ADDR_W'(i))              rdWord = liveReg[i];
        if (rdAddr == A_CFG_LO + SHADOW_OFS + ADDR_W'(i)) rdWord = shadowReg[i];
      end
    end
  end

  assign extRefSel = liveReg[CFG_IDX][EXTREF_BIT];

  p_live_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && !unlocked) |=> $stable(liveReg));

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrStb |=> $stable(faultFlag));

  p_fault_copies_r7: assert property (@(posedge clk) disable iff (!rstN)
    !faultFlag |-> (&touched));

  p_unlock_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && cmd.addr == A_UNLOCK) |=> (unlockReg == $past(cmd.data)));

  p_shadow_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && cmd.addr == A_CFG_LO + SHADOW_OFS) |=> (shadowReg[0] == $past(cmd.data)));
endmodule

// File: rtl/vreg_spi_bank.sv
module vreg_spi_bank
  import vreg_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 10'h294
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              extRefSel
);
  cmd_t              cmd;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdWord;

  vreg_spi_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .csN    (csN),
    .mosi   (mosi),
    .miso   (miso),
    .rdWord (rdWord),
    .rdAddr (rdAddr),
    .cmd    (cmd)
  );

  vreg_datapath #(.UNLOCK_KEY(UNLOCK_KEY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .rdAddr    (rdAddr),
    .sampleIn  (sampleIn),
    .rdWord    (rdWord),
    .extRefSel (extRefSel)
  );
endmodule

// File: tb/vreg_spi_bank_bench.sv
module vreg_spi_bank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic [9:0] sampleIn = '0;
  logic extRefSel;
  int total = 0;
  int bad = 0;
  localparam int HALF = 6;

  always #4 clk = ~clk;

  vreg_spi_bank u_vreg_spi_bank (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .sampleIn(sampleIn), .extRefSel(extRefSel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // frame bit 0 goes out first; nClk rising edges before release
  task automatic frame(input logic [15:0] tx, input int nClk, output logic [15:0] rx);
    rx = '0;
    @(negedge clk);
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < nClk; i++) begin
      mosi = (i < 16) ? tx[i] : 1'b0;
      waitClk(HALF);
      if (i < 16) rx[i] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(8);
  endtask

  function automatic logic [15:0] enc(input logic [4:0] a, input logic w, input logic [9:0] d);
    return {a, w, d};
  endfunction

  task automatic wrReg(input logic [4:0] a, input logic [9:0] d);
    logic [15:0] rx;
    frame(enc(a, 1'b1, d), 16, rx);
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [15:0] w);
    logic [15:0] rx;
    frame(enc(a, 1'b0, 10'h0), 16, rx);
    frame(16'h0000, 16, w);
  endtask

  task automatic t_reset;
    logic [15:0] w;
    chk("R9 extRef after reset", {15'b0, extRefSel}, 16'h0);
    rdReg(5'h02, w); chk("R7 fault after reset", w, 16'h0001);
    rdReg(5'h0C, w); chk("R5 unlock reg reset", w, 16'h0000);
  endtask

  task automatic t_sample;
    logic [15:0] w;
    sampleIn = 10'h2A5;
    rdReg(5'h00, w); chk("R3 R2 result read", w, 16'h02A5);
    sampleIn = 10'h3FF;
    rdReg(5'h01, w); chk("R3 R1 filtered read, upper zero", w, 16'h03FF);
  endtask

  task automatic t_locked;
    logic [15:0] w;
    wrReg(5'h09, 10'h020);
    rdReg(5'h09, w); chk("R4 locked write ignored", w, 16'h0000);
    chk("R9 extRef locked", {15'b0, extRefSel}, 16'h0);
  endtask

  task automatic t_unlock;
    logic [15:0] w;
    wrReg(5'h0C, 10'h294);
    rdReg(5'h0C, w); chk("R5 key readback", w, 16'h0294);
    wrReg(5'h09, 10'h020);
    rdReg(5'h09, w); chk("R4 unlocked write", w, 16'h0020);
    chk("R9 extRef set", {15'b0, extRefSel}, 16'h1);
    wrReg(5'h0C, 10'h000);
    wrReg(5'h09, 10'h000);
    rdReg(5'h09, w); chk("R5 relock blocks write", w, 16'h0020);
    wrReg(5'h0C, 10'h293);
    wrReg(5'h09, 10'h000);
    rdReg(5'h09, w); chk("R5 wrong key stays locked", w, 16'h0020);
  endtask

  task automatic t_shadow;
    logic [15:0] w;
    wrReg(5'h19, 10'h020);
    rdReg(5'h19, w); chk("R6 shadow write while locked", w, 16'h0020);
    rdReg(5'h02, w); chk("R7 fault with copies missing", w, 16'h0001);
    for (int a = 5'h13; a <= 5'h1A; a++)
      if (a != 5'h19) wrReg(5'(a), 10'h000);
    rdReg(5'h02, w); chk("R7 fault cleared by last copy", w, 16'h0000);
  endtask

  task automatic t_mismatch;
    logic [15:0] w;
    wrReg(5'h0C, 10'h294);
    wrReg(5'h04, 10'h155);
    rdReg(5'h02, w); chk("R8 mismatch raises fault", w, 16'h0001);
    wrReg(5'h14, 10'h155);
    rdReg(5'h02, w); chk("R8 matching copy clears fault", w, 16'h0000);
  endtask

  task automatic t_readonly;
    logic [15:0] w;
    sampleIn = 10'h0C3;
    wrReg(5'h00, 10'h3FF);
    rdReg(5'h00, w); chk("R10 result not writable", w, 16'h00C3);
    wrReg(5'h02, 10'h001);
    rdReg(5'h02, w); chk("R10 flags not writable", w, 16'h0000);
    wrReg(5'h0E, 10'h123);
    rdReg(5'h0E, w); chk("R10 unmapped reads zero", w, 16'h0000);
    rdReg(5'h1F, w); chk("R10 unmapped high reads zero", w, 16'h0000);
  endtask

  task automatic t_short;
    logic [15:0] w, rx;
    frame(enc(5'h05, 1'b1, 10'h0AA), 12, rx);
    rdReg(5'h05, w); chk("R11 short frame dropped", w, 16'h0000);
    frame(enc(5'h05, 1'b1, 10'h0AA), 17, rx);
    rdReg(5'h05, w); chk("R11 long frame dropped", w, 16'h0000);
    frame(enc(5'h04, 1'b0, 10'h0), 16, rx);
    frame(enc(5'h0C, 1'b0, 10'h0), 9, rx);
    frame(16'h0000, 16, w); chk("R11 short read keeps address", w, 16'h0155);
    wrReg(5'h05, 10'h0AA);
    rdReg(5'h05, w); chk("R1 full frame lands", w, 16'h00AA);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    t_reset();
    t_sample();
    t_locked();
    t_unlock();
    t_shadow();
    t_mismatch();
    t_readonly();
    t_short();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule